// File: doc/BRIEF.md
# DDR2 Command Sequencer

This block turns single-word memory requests into the control pin levels of a DDR2 SDRAM device: clock enable, chip select, the three command strobes, the bank address and the multiplexed address bus. A requester offers an operation code with its bank, row or mode value, column and a flag on a valid/ready handshake. Each accepted request becomes one registered command on the pins. Cycles without a command carry a NOP, or carry a low-power hold after a power-down or self-refresh entry.

After reset the block runs the start-up sequence without any request. It holds clock enable low for a set number of clocks and then issues NOPs for the long settle interval. Only after that does it raise ready. The same sequence can be started again on request. After every command, ready stays low for a gap of cycles that the requester chooses with each request.

The block keeps a copy of both mode registers as they are written on the bus. It decodes that copy into CAS latency, additive latency, burst order, burst length, read latency and write latency, so that a data path can follow the current settings.

Top module: `dram_cmd_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, CKE is low, CS#, RAS#, CAS# and WE# are high, bank and address are zero, ready is low and both mode copies are zero: CAS latency 0, additive latency 0, burst order 0, burst length 1, read latency 0, write latency 15.
- R2: After reset release, CKE stays low with CS# high until rising edge CKE_LOW_CYCLES. From that edge NOP is driven (CKE high, CS# low, other strobes high) and ready rises at edge CKE_LOW_CYCLES+INIT_NOP_CYCLES.
- R3: Operation codes: 0 NOP, 1 deselect, 2 mode load, 3 refresh, 4 precharge, 5 activate, 6 read, 7 write, 8 power-down, 9 self-refresh, 10 power-up. A request is accepted at a rising edge where valid and ready are both high, and its command appears on the pins after that edge. Ready then stays low for exactly the number of cycles given on the gap input at acceptance, and stays high when the gap is 0. Valid while ready is low has no effect. Cycles without a command carry NOP unless R8 says otherwise.
- R4: Mode load drives CS#, RAS#, CAS# and WE# low with CKE high, the request bank on the bank pins and the request value on the address pins. Bank 0 updates the mode register copy, bank 1 updates the extended copy, and any other bank changes neither copy.
- R5: Refresh drives CS#, RAS# and CAS# low with WE# and CKE high. Self-refresh drives the same strobes with CKE low. In the next cycle without a new command, all four strobes are high with CKE still low.
- R6: Precharge drives CS#, RAS# and WE# low with CAS# high and the request bank. Address bit 10 equals the request flag (all banks), and all other address bits are 0. Activate drives CS# and RAS# low with CAS# and WE# high, the request bank, and the request row value on the address pins.
- R7: Read drives CS# and CAS# low with RAS# and WE# high. Write drives CS#, CAS# and WE# low with RAS# high. For both, address bits 9:0 carry column bits 9:0, address bit 10 carries the auto-precharge flag, address bit 11 and up carry column bits 10 and up, and unused address bits are 0.
- R8: NOP drives CS# low with the strobes high. Deselect drives CS# high with CKE high. Power-down drives CKE low with CS# and the strobes high. After power-down or self-refresh, every cycle without a command holds CKE low with CS# and the strobes high until the next accepted command. Codes 11 to 15 behave as NOP.
- R9: CAS latency is bits 6:4 of the mode copy, burst order is bit 3, and burst length is 2 to the power of bits 2:0. Additive latency is bits 5:3 of the extended copy. Each is visible in the cycle after the mode load is accepted.
- R10: Read latency is additive plus CAS latency, and write latency is read latency minus one, both modulo 16.
- R11: The power-up code drives CKE low with CS# high and reruns the R2 timing counted from its accepting edge: CKE rises at the CKE_LOW_CYCLES-th edge after it and ready returns INIT_NOP_CYCLES edges later. The mode copies are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request may be accepted this cycle |
| reqOp | input | 4 | Operation code (R3) |
| reqBank | input | BA_W | Bank for the request |
| reqAddr | input | ADDR_W | Row for activate, value for mode load |
| reqCol | input | COL_W | Column for read and write |
| reqFlag | input | 1 | Auto-precharge for read/write, all banks for precharge |
| reqGap | input | GAP_W | NOP cycles to hold ready low after this command |
| memCke | output | 1 | Clock enable pin |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memBa | output | BA_W | Bank address pins |
| memAddr | output | ADDR_W | Address pins |
| casLat | output | 3 | Decoded CAS latency |
| addLat | output | 3 | Decoded additive latency |
| burstOrder | output | 1 | Decoded burst order |
| burstLen | output | 8 | Decoded burst length |
| readLat | output | 4 | Additive plus CAS latency |
| writeLat | output | 4 | Read latency minus one |

## Verification
Each command, the ready level and the decoded latencies are due one clock after the rising edge that accepts the request, because every one of them passes through a single register stage. The start-up results are due at edge CKE_LOW_CYCLES for CKE and at edge CKE_LOW_CYCLES+INIT_NOP_CYCLES for ready. The bench model updates its expected pins, ready and mode copies at each rising edge from the inputs held since the previous falling edge. It compares every output at the next falling edge, so each result is sampled in the cycle it is due and never an edge early. The gap, ignored-valid and low-power hold cases are covered by the same per-clock comparison.

// File: rtl/dram_cmd_pkg.sv
package dram_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_DESEL     = 4'd1,
    OP_MODE      = 4'd2,
    OP_REFRESH   = 4'd3,
    OP_PRECHARGE = 4'd4,
    OP_ACTIVATE  = 4'd5,
    OP_READ      = 4'd6,
    OP_WRITE     = 4'd7,
    OP_PDOWN     = 4'd8,
    OP_SELFREF   = 4'd9,
    OP_PWRUP     = 4'd10
  } reqOp_e;

  // Strobes from control to datapath for one clock.
  typedef struct packed {
    logic issue;   // encode the offered request this edge
    logic sleep;   // filler is a low-power hold instead of NOP
  } ctrlStrobe_t;

  typedef struct packed {
    logic cke;
    logic csN;
    logic rasN;
    logic casN;
    logic weN;
  } pinSet_t;

  function automatic pinSet_t mkPins(input logic cke, input logic cs,
                                     input logic ras, input logic cas,
                                     input logic we);
    pinSet_t p;
    p.cke  = cke;
    p.csN  = cs;
    p.rasN = ras;
    p.casN = cas;
    p.weN  = we;
    return p;
  endfunction

  localparam pinSet_t PINS_NOP   = '{cke: 1'b1, csN: 1'b0, rasN: 1'b1, casN: 1'b1, weN: 1'b1};
  localparam pinSet_t PINS_SLEEP = '{cke: 1'b0, csN: 1'b1, rasN: 1'b1, casN: 1'b1, weN: 1'b1};

endpackage

// File: rtl/dram_cmd_ctrl.sv
module dram_cmd_ctrl
  import dram_cmd_pkg::*;
#(
  parameter int CKE_LOW_CYCLES  = 10,
  parameter int INIT_NOP_CYCLES = 40000,
  parameter int GAP_W           = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [3:0]       reqOp,
  input  logic [GAP_W-1:0] reqGap,
  output logic             reqReady,
  output ctrlStrobe_t      strobe
);

  localparam int PU_MAX = (CKE_LOW_CYCLES > INIT_NOP_CYCLES) ? CKE_LOW_CYCLES : INIT_NOP_CYCLES;
  localparam int PU_W   = $clog2(PU_MAX + 1);
  localparam int CNT_W  = (PU_W > GAP_W) ? PU_W : GAP_W;
  localparam logic [CNT_W-1:0] LOW_LOAD = CNT_W'(CKE_LOW_CYCLES - 1);
  localparam logic [CNT_W-1:0] NOP_LOAD = CNT_W'(INIT_NOP_CYCLES - 1);

  typedef enum logic [1:0] {
    ST_PU_LOW,
    ST_PU_NOP,
    ST_IDLE,
    ST_GAP
  } seqState_e;

  seqState_e        state;
  logic [CNT_W-1:0] cnt;
  logic             lowPower;
  logic             accept;
  logic             cntZero;
  logic             sleepOp;

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    accept       = reqValid && reqReady;
    cntZero      = (cnt == '0);
    sleepOp      = (reqOp == OP_PDOWN) || (reqOp == OP_SELFREF);
    strobe.issue = accept;
    unique case (state)
      ST_PU_LOW: strobe.sleep = !cntZero;
      ST_PU_NOP: strobe.sleep = 1'b0;
      default:   strobe.sleep = lowPower;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_PU_LOW;
      cnt      <= LOW_LOAD;
      lowPower <= 1'b0;
    end else begin
      unique case (state)
        ST_PU_LOW: begin
          if (cntZero) begin
            state <= ST_PU_NOP;
            cnt   <= NOP_LOAD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_PU_NOP, ST_GAP: begin
          if (cntZero) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        ST_IDLE: begin
          if (accept) begin
            lowPower <= sleepOp;
            if (reqOp == OP_PWRUP) begin
              state <= ST_PU_LOW;
              cnt   <= LOW_LOAD;
            end else if (reqGap != '0) begin
              state <= ST_GAP;
              cnt   <= CNT_W'(reqGap) - CNT_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dram_cmd_dp.sv
module dram_cmd_dp
  import dram_cmd_pkg::*;
#(
  parameter int BA_W   = 2,
  parameter int ADDR_W = 14,
  parameter int COL_W  = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [3:0]        reqOp,
  input  logic [BA_W-1:0]   reqBank,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqFlag,
  output pinSet_t           pins,
  output logic [BA_W-1:0]   memBa,
  output logic [ADDR_W-1:0] memAddr,
  output logic [2:0]        casLat,
  output logic [2:0]        addLat,
  output logic              burstOrder,
  output logic [7:0]        burstLen,
  output logic [3:0]        readLat,
  output logic [3:0]        writeLat
);

  localparam int AP_BIT  = 10;   // flag position, skipped by the column map
  localparam int COL_LOW = 10;   // column bits that map straight across

  logic [ADDR_W-1:0] colMapped;
  logic [ADDR_W-1:0] apOnly;
  logic [6:0]        modeCopy;   // fields of the mode register that are decoded
  logic [2:0]        extAl;      // additive latency field of the extended register
  pinSet_t           nxtPins;
  logic [BA_W-1:0]   nxtBa;
  logic [ADDR_W-1:0] nxtAddr;
  logic              modeWr;

  // Column to address mapping with bit 10 reserved for the flag.
  for (genvar b = 0; b < ADDR_W; b++) begin : g_colmap
    if (b < COL_LOW) begin : g_low
      if (b < COL_W) begin : g_src
        assign colMapped[b] = reqCol[b];
      end else begin : g_pad
        assign colMapped[b] = 1'b0;
      end
    end else if (b == AP_BIT) begin : g_ap
      assign colMapped[b] = reqFlag;
    end else begin : g_high
      if (b - 1 < COL_W) begin : g_src
        assign colMapped[b] = reqCol[b-1];
      end else begin : g_pad
        assign colMapped[b] = 1'b0;
      end
    end
  end

  assign apOnly = ADDR_W'(reqFlag) << AP_BIT;
  assign modeWr = strobe.issue && (reqOp == OP_MODE);

  always_comb begin
    nxtPins = strobe.sleep ? PINS_SLEEP : PINS_NOP;
    nxtBa   = '0;
    nxtAddr = '0;
    if (strobe.issue) begin
      unique case (reqOp)
        OP_DESEL:     nxtPins = mkPins(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        OP_MODE: begin
          nxtPins = mkPins(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
          nxtBa   = reqBank;
          nxtAddr = reqAddr;
        end
        OP_REFRESH:   nxtPins = mkPins(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        OP_PRECHARGE: begin
          nxtPins = mkPins(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
          nxtBa   = reqBank;
          nxtAddr = apOnly;
        end
        OP_ACTIVATE: begin
          nxtPins = mkPins(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
          nxtBa   = reqBank;
          nxtAddr = reqAddr;
        end
        OP_READ: begin
          nxtPins = mkPins(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
          nxtBa   = reqBank;
          nxtAddr = colMapped;
        end
        OP_WRITE: begin
          nxtPins = mkPins(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
          nxtBa   = reqBank;
          nxtAddr = colMapped;
        end
        OP_PDOWN:     nxtPins = PINS_SLEEP;
        OP_SELFREF:   nxtPins = mkPins(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        OP_PWRUP:     nxtPins = PINS_SLEEP;
        default:      nxtPins = PINS_NOP;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pins     <= PINS_SLEEP;
      memBa    <= '0;
      memAddr  <= '0;
      modeCopy <= '0;
      extAl    <= '0;
    end else begin
      pins    <= nxtPins;
      memBa   <= nxtBa;
      memAddr <= nxtAddr;
      if (modeWr && reqBank == BA_W'(0)) modeCopy <= reqAddr[6:0];
      if (modeWr && reqBank == BA_W'(1)) extAl    <= reqAddr[5:3];
    end
  end

  // Live latency decode from the shadow copies.
  always_comb begin
    casLat     = modeCopy[6:4];
    burstOrder = modeCopy[3];
    burstLen   = 8'd1 << modeCopy[2:0];
    addLat     = extAl;
    readLat    = {1'b0, casLat} + {1'b0, addLat};
    writeLat   = readLat - 4'd1;
  end

endmodule

// File: rtl/dram_cmd_seq.sv
module dram_cmd_seq
  import dram_cmd_pkg::*;
#(
  parameter int BA_W            = 2,
  parameter int ADDR_W          = 14,
  parameter int COL_W           = 11,
  parameter int GAP_W           = 4,
  parameter int CKE_LOW_CYCLES  = 10,
  parameter int INIT_NOP_CYCLES = 40000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [3:0]        reqOp,
  input  logic [BA_W-1:0]   reqBank,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqFlag,
  input  logic [GAP_W-1:0]  reqGap,
  output logic              memCke,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [BA_W-1:0]   memBa,
  output logic [ADDR_W-1:0] memAddr,
  output logic [2:0]        casLat,
  output logic [2:0]        addLat,
  output logic              burstOrder,
  output logic [7:0]        burstLen,
  output logic [3:0]        readLat,
  output logic [3:0]        writeLat
);

  ctrlStrobe_t strobe;
  pinSet_t     pins;

  dram_cmd_ctrl #(
    .CKE_LOW_CYCLES (CKE_LOW_CYCLES),
    .INIT_NOP_CYCLES(INIT_NOP_CYCLES),
    .GAP_W          (GAP_W)
  ) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqOp   (reqOp),
    .reqGap  (reqGap),
    .reqReady(reqReady),
    .strobe  (strobe)
  );

  dram_cmd_dp #(
    .BA_W  (BA_W),
    .ADDR_W(ADDR_W),
    .COL_W (COL_W)
  ) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqOp     (reqOp),
    .reqBank   (reqBank),
    .reqAddr   (reqAddr),
    .reqCol    (reqCol),
    .reqFlag   (reqFlag),
    .pins      (pins),
    .memBa     (memBa),
    .memAddr   (memAddr),
    .casLat    (casLat),
    .addLat    (addLat),
    .burstOrder(burstOrder),
    .burstLen  (burstLen),
    .readLat   (readLat),
    .writeLat  (writeLat)
  );

  assign memCke  = pins.cke;
  assign memCsN  = pins.csN;
  assign memRasN = pins.rasN;
  assign memCasN = pins.casN;
  assign memWeN  = pins.weN;

endmodule

// File: rtl/dram_cmd_seq_chk.sv
module dram_cmd_seq_chk #(
  parameter int GAP_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [3:0]       reqOp,
  input logic [GAP_W-1:0] reqGap,
  input logic             reqFlag,
  input logic             memCke,
  input logic             memCsN,
  input logic             memRasN,
  input logic             memCasN,
  input logic             memWeN,
  input logic             memAp,
  input logic [2:0]       casLat,
  input logic [2:0]       addLat,
  input logic             burstOrder,
  input logic [7:0]       burstLen
);

  logic accepted;
  logic pinCmd;
  assign accepted = reqValid && reqReady;
  assign pinCmd   = !memCsN && !(memRasN && memCasN && memWeN);

  assert_gap_drops_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqOp != 4'd10 && reqGap != '0) |=> !reqReady);

  assert_zero_gap_keeps_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    (accepted && reqOp != 4'd10 && reqGap == '0) |=> reqReady);

  assert_cmd_needs_accept_R3: assert property (@(posedge clk) disable iff (!rstN)
    pinCmd |-> $past(accepted));

  assert_selfref_one_cycle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!memCke && !memCsN && !accepted) |=> (!memCke && memCsN && memRasN && memCasN && memWeN));

  assert_mode_copy_stable_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(accepted && reqOp == 4'd2) |=>
      ($stable(casLat) && $stable(addLat) && $stable(burstOrder) && $stable(burstLen)));

  assert_autopre_bit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && memRasN && !memCasN) |-> (memAp == $past(reqFlag)));

endmodule

bind dram_cmd_seq dram_cmd_seq_chk #(.GAP_W(GAP_W)) chkInst (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqOp     (reqOp),
  .reqGap    (reqGap),
  .reqFlag   (reqFlag),
  .memCke    (memCke),
  .memCsN    (memCsN),
  .memRasN   (memRasN),
  .memCasN   (memCasN),
  .memWeN    (memWeN),
  .memAp     (memAddr[10]),
  .casLat    (casLat),
  .addLat    (addLat),
  .burstOrder(burstOrder),
  .burstLen  (burstLen)
);

// File: tb/dram_cmd_seq_test.sv
`timescale 1ns / 1ps
module dram_cmd_seq_test;

  localparam int C_LOW = 4;
  localparam int N_NOP = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [3:0]  reqOp = 4'd0;
  logic [1:0]  reqBank = '0;
  logic [13:0] reqAddr = '0;
  logic [10:0] reqCol = '0;
  logic        reqFlag = 1'b0;
  logic [3:0]  reqGap = '0;
  logic        memCke, memCsN, memRasN, memCasN, memWeN;
  logic [1:0]  memBa;
  logic [13:0] memAddr;
  logic [2:0]  casLat, addLat;
  logic        burstOrder;
  logic [7:0]  burstLen;
  logic [3:0]  readLat, writeLat;

  dram_cmd_seq #(
    .BA_W(2), .ADDR_W(14), .COL_W(11), .GAP_W(4),
    .CKE_LOW_CYCLES(C_LOW), .INIT_NOP_CYCLES(N_NOP)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqBank(reqBank), .reqAddr(reqAddr), .reqCol(reqCol),
    .reqFlag(reqFlag), .reqGap(reqGap),
    .memCke(memCke), .memCsN(memCsN), .memRasN(memRasN), .memCasN(memCasN),
    .memWeN(memWeN), .memBa(memBa), .memAddr(memAddr),
    .casLat(casLat), .addLat(addLat), .burstOrder(burstOrder),
    .burstLen(burstLen), .readLat(readLat), .writeLat(writeLat)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit finished = 0;

  // Reference model state
  int          puLow = C_LOW;
  int          puNop = 0;
  int          gapLeft = 0;
  bit          sleepF = 0;
  bit          mReady = 0;
  logic [4:0]  expPins = 5'b01111;
  logic [1:0]  expBa = '0;
  logic [13:0] expAddr = '0;
  logic [13:0] m0 = '0;
  logic [13:0] m1 = '0;
  string       tag = "R1";

  task automatic setExp(input logic [4:0] p, input logic [1:0] b, input logic [13:0] a);
    expPins = p;
    expBa   = b;
    expAddr = a;
  endtask

  function automatic logic [13:0] mapCol(input logic [10:0] c, input logic f);
    int v;
    v = (int'(c) & 'h3FF) | ((int'(c) >> 10) << 11) | (int'(f) << 10);
    return v[13:0];
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      puLow = C_LOW; puNop = 0; gapLeft = 0; sleepF = 0;
      m0 = '0; m1 = '0; tag = "R1";
      setExp(5'b01111, '0, '0);
      mReady = 0;
    end else begin
      bit acc;
      acc = reqValid && mReady;
      if (puLow > 0) begin
        puLow--;
        tag = (tag == "R11") ? "R11" : "R2";
        if (puLow == 0) begin puNop = N_NOP; setExp(5'b10111, '0, '0); end
        else setExp(5'b01111, '0, '0);
      end else if (puNop > 0) begin
        puNop--;
        setExp(5'b10111, '0, '0);
      end else if (gapLeft > 0 || !acc) begin
        if (gapLeft > 0) gapLeft--;
        if (sleepF) begin setExp(5'b01111, '0, '0); tag = "R8"; end
        else begin setExp(5'b10111, '0, '0); tag = "R3"; end
      end else begin
        gapLeft = int'(reqGap);
        sleepF  = (reqOp == 4'd8) || (reqOp == 4'd9);
        case (reqOp)
          4'd1: begin setExp(5'b11111, '0, '0); tag = "R8"; end
          4'd2: begin
            setExp(5'b10000, reqBank, reqAddr); tag = "R4";
            if (reqBank == 2'd0) m0 = reqAddr;
            if (reqBank == 2'd1) m1 = reqAddr;
          end
          4'd3: begin setExp(5'b10001, '0, '0); tag = "R5"; end
          4'd4: begin setExp(5'b10010, reqBank, reqFlag ? 14'd1024 : 14'd0); tag = "R6"; end
          4'd5: begin setExp(5'b10011, reqBank, reqAddr); tag = "R6"; end
          4'd6: begin setExp(5'b10101, reqBank, mapCol(reqCol, reqFlag)); tag = "R7"; end
          4'd7: begin setExp(5'b10100, reqBank, mapCol(reqCol, reqFlag)); tag = "R7"; end
          4'd8: begin setExp(5'b01111, '0, '0); tag = "R8"; end
          4'd9: begin setExp(5'b00001, '0, '0); tag = "R5"; end
          4'd10: begin setExp(5'b01111, '0, '0); tag = "R11"; puLow = C_LOW; gapLeft = 0; end
          default: begin setExp(5'b10111, '0, '0); tag = "R8"; end
        endcase
      end
      mReady = (puLow == 0) && (puNop == 0) && (gapLeft == 0);
    end
  end

  task automatic check(input string t, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", t, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cycles > 0 && !finished) begin
      int cl, al, rl, wl;
      cl = int'(m0[6:4]);
      al = int'(m1[5:3]);
      rl = (cl + al) % 16;
      wl = (cl + al + 15) % 16;
      check(tag, "pins", int'({memCke, memCsN, memRasN, memCasN, memWeN}), int'(expPins));
      check(tag, "bank/addr", int'({memBa, memAddr}), int'({expBa, expAddr}));
      check((puLow > 0 || puNop > 0) ? "R2" : "R3", "ready", int'(reqReady), int'(mReady));
      check("R9", "mode decode", int'({casLat, burstOrder, burstLen, addLat}),
            int'({m0[6:4], m0[3], 8'(1 << m0[2:0]), m1[5:3]}));
      check("R10", "latencies", int'({readLat, writeLat}), (rl << 4) | wl);
    end
  end

  task automatic issue(input logic [3:0] op, input logic [1:0] bank, input logic [13:0] addr,
                       input logic [10:0] col, input logic flag, input logic [3:0] gap);
    while (!reqReady) @(negedge clk);
    reqOp = op; reqBank = bank; reqAddr = addr; reqCol = col; reqFlag = flag; reqGap = gap;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);   // R1: reset state compared each cycle
    rstN = 1'b1;
    issue(4'd2, 2'd0, 14'h004B, '0, 1'b0, 4'd2);   // R4 mode: CL4, order 1, burst 8
    issue(4'd2, 2'd1, 14'h0010, '0, 1'b0, 4'd0);   // R4 extended: AL2
    issue(4'd2, 2'd2, 14'h3FFF, '0, 1'b0, 4'd1);   // R4 bank 2 leaves copies
    issue(4'd4, 2'd0, 14'h3FFF, '0, 1'b1, 4'd1);   // R6 precharge all
    issue(4'd4, 2'd3, '0, '0, 1'b0, 4'd0);         // R6 single bank
    issue(4'd5, 2'd2, 14'h2A5C, '0, 1'b0, 4'd3);   // R6 activate
    issue(4'd6, 2'd2, '0, 11'h5A5, 1'b1, 4'd0);    // R7 read high column, autopre
    issue(4'd7, 2'd1, '0, 11'h3FF, 1'b0, 4'd2);    // R7 write
    issue(4'd3, 2'd0, '0, '0, 1'b0, 4'd1);         // R5 refresh
    issue(4'd9, 2'd0, '0, '0, 1'b0, 4'd0);         // R5 self-refresh
    repeat (3) @(negedge clk);                     // R5/R8 low-power hold
    issue(4'd0, 2'd0, '0, '0, 1'b0, 4'd0);         // R8 NOP wakes
    issue(4'd8, 2'd0, '0, '0, 1'b0, 4'd3);         // R8 power-down with gap
    repeat (4) @(negedge clk);
    issue(4'd1, 2'd0, '0, '0, 1'b0, 4'd0);         // R8 deselect
    issue(4'd13, 2'd3, 14'h1234, 11'h7FF, 1'b1, 4'd0); // R8 unknown code
    issue(4'd5, 2'd1, 14'h0001, '0, 1'b0, 4'd6);   // R3 gap, then valid ignored
    reqOp = 4'd2; reqBank = 2'd0; reqAddr = 14'h007F; reqValid = 1'b1;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    issue(4'd6, 2'd0, '0, 11'h001, 1'b0, 4'd0);    // R3 back-to-back
    issue(4'd7, 2'd0, '0, 11'h400, 1'b1, 4'd0);    // R7 column bit 10 to addr 11
    issue(4'd2, 2'd0, 14'h0000, '0, 1'b0, 4'd0);   // R10 CL0
    issue(4'd2, 2'd1, 14'h0000, '0, 1'b0, 4'd0);   // R10 write latency wraps to 15
    issue(4'd2, 2'd0, 14'h0072, '0, 1'b0, 4'd0);   // R9 CL7, burst 4
    issue(4'd10, 2'd0, '0, '0, 1'b0, 4'd5);        // R11 restart power-up
    issue(4'd6, 2'd3, '0, 11'h0AB, 1'b0, 4'd0);    // R11 accepted after restart
    repeat (5) @(negedge clk);
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

endmodule